// File: doc/BRIEF.md
# Transmit FIFO Data-Request Controller

This block sits between a host that supplies transmit data in 16-bit words and a MAC that takes it one byte at a time. It holds the bytes in a small FIFO and drives a data-request line to the host. The request is based on how much free space the FIFO has, compared with a programmable watermark. A burst mode is also available. In burst mode, the request stays up until the FIFO is nearly full, or until it is close to full at the end of a frame. Either way, the host always keeps room for one more whole word.

Changing the watermark is a staged operation. Software can write a pending watermark code at any time and read it back unchanged. The request logic keeps using the active code until an update flag is raised. The cycle after the flag is set, three things happen together: the pending code becomes active, the FIFO pointers are cleared, and the flag clears itself. A transmit-path reset after a retry failure does the same load and flush. A software reset returns everything to its defaults.

Top module: `txfifo_req_ctrl`

## Requirements
- R1: After reset the FIFO is empty, overflow is 0, the update flag reads 0, the watermark reads code 2'b10, and the request is high because the free space equals the full depth.
- R2: A host word write queues its low byte before its high byte, the MAC reads bytes in the order they were written, and a pop while empty changes nothing.
- R3: A host write when fewer than two bytes are free is dropped and sets a sticky overflow output, which only hardware or software reset clears.
- R4: Outside burst mode the request is high exactly when the free space is at least the active threshold: code 2'b00 selects DEPTH/4 bytes, 2'b01 selects DEPTH/2, and 2'b10 or 2'b11 select DEPTH.
- R5: A configuration write stores the watermark code, which reads back in the next cycle, and the request logic keeps using the old active code.
- R6: When the update flag is set, the next clock edge loads the pending code into the active code, empties the FIFO and clears the flag.
- R7: A transmit-path retry reset loads the pending code, empties the FIFO and clears the update flag.
- R8: In burst mode, once the request is high it stays high while more than two bytes are free, even below the threshold, and it drops at two or fewer.
- R9: In burst mode, a held request drops when four or fewer bytes are free and the host end-of-frame input is high.
- R10: Software reset empties the FIFO, clears overflow and the update flag, and restores the pending and active codes to 2'b10. It takes priority over a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset, synchronous |
| retry_rst | input | 1 | Transmit-path reset after a retry failure |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wmark | input | 2 | Watermark code to stage |
| cfg_update | input | 1 | Update flag value written with the code |
| burst_en | input | 1 | Burst request mode select |
| host_we | input | 1 | Host word write |
| host_word | input | 16 | Host data, low byte queued first |
| host_eof | input | 1 | Host end-of-frame indication |
| mac_pop | input | 1 | MAC takes the head byte |
| mac_byte | output | 8 | Head byte of the FIFO |
| fifo_empty | output | 1 | FIFO holds no bytes |
| tx_req | output | 1 | Data request to the host |
| overflow | output | 1 | Sticky dropped-write flag |
| wmark_rd | output | 2 | Pending watermark read-back |
| update_rd | output | 1 | Update flag read-back |

## Verification
The bench builds the block with the default 64-byte depth. At that depth the three thresholds are 16, 32 and 64 bytes. Random bursts of writes and pops therefore sweep the free space across every threshold, the two-byte burst floor, the four-byte end-of-frame limit and the full condition. Because pushes are always two bytes and pops are single bytes, the byte count can be odd. This means writes are attempted with exactly one byte free.

// File: rtl/txq_pkg.sv
// Package: shared watermark codes and threshold decode for the transmit FIFO.
// Assumes the FIFO depth is a multiple of four.
package txq_pkg;

    typedef enum logic [1:0] {
        WM_QUARTER = 2'b00,
        WM_HALF    = 2'b01,
        WM_FULL    = 2'b10,
        WM_SPARE   = 2'b11
    } wmark_e;

    localparam logic [1:0] WM_DEFAULT = WM_FULL;

    // Free-space threshold in bytes for a watermark code
    function automatic int unsigned wmark_bytes(input logic [1:0] code, input int unsigned depth);
        case (wmark_e'(code))
            WM_QUARTER: return depth / 4;
            WM_HALF:    return depth / 2;
            default:    return depth;
        endcase
    endfunction

endpackage

// File: rtl/txq_store.sv
// Module: byte FIFO storage and pointers. Accepts 16-bit word pushes
// (low byte first) and single-byte pops. Pointers carry one extra bit so
// that full and empty can be told apart. A flush clears both pointers and
// overrides push and pop. Assumes DEPTH is a power of two, at least 8.
module txq_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          ovf_clr,
    input  logic          push,
    input  logic [15:0]   word,
    input  logic          pop,
    output logic [7:0]    head,
    output logic          empty,
    output logic [CW-1:0] free,
    output logic          ovf
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] wr_q, rd_q, used;
    logic [AW-1:0] wr_lo, wr_hi;
    logic          push_ok, pop_ok;

    // Occupancy and free space from the extended pointers
    always_comb begin
        used    = wr_q - rd_q;
        free    = CW'(DEPTH) - used;
        empty   = (used == '0);
        wr_lo   = wr_q[AW-1:0];
        wr_hi   = wr_lo + AW'(1);
        push_ok = push && (free >= CW'(2));
        pop_ok  = pop && !empty;
        head    = mem[rd_q[AW-1:0]];
    end

    // Byte storage: a word occupies two consecutive slots
    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_lo] <= word[7:0];
            mem[wr_hi] <= word[15:8];
        end
    end

    // Pointer movement, flush and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            ovf  <= 1'b0;
        end else begin
            if (flush) begin
                wr_q <= '0;
                rd_q <= '0;
            end else begin
                if (push_ok) wr_q <= wr_q + CW'(2);
                if (pop_ok)  rd_q <= rd_q + CW'(1);
            end
            if (ovf_clr)
                ovf <= 1'b0;
            else if (push && !push_ok && !flush)
                ovf <= 1'b1;
        end
    end

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CW'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push && free < CW'(2) && !flush && !ovf_clr |=> ovf);
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/txq_wmark.sv
// Module: staged watermark register. The pending code is written at any
// time and read back as written. It is copied to the active code when the
// update flag is set or a retry reset arrives, and that same event flushes
// the FIFO. The flag clears itself after the load. Software reset restores
// the defaults and takes priority over a configuration write.
module txq_wmark
    import txq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       retry_rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wmark,
    input  logic       cfg_update,
    output logic [1:0] pend,
    output logic [1:0] act,
    output logic       upd,
    output logic       flush
);
    logic load;

    // Load event and FIFO flush request
    always_comb begin
        load  = upd || retry_rst;
        flush = sw_rst || load;
    end

    // Pending, active and update-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            pend <= WM_DEFAULT;
            act  <= WM_DEFAULT;
            upd  <= 1'b0;
        end else begin
            if (load) act <= pend;
            if (cfg_we) begin
                pend <= cfg_wmark;
                upd  <= cfg_update;
            end else if (load) begin
                upd <= 1'b0;
            end
        end
    end

    p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !sw_rst |=> pend == $past(cfg_wmark));
    p_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd && !cfg_we |=> !upd);
    p_retry_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retry_rst && !sw_rst |=> act == $past(pend));
endmodule

// File: rtl/txq_req.sv
// Module: data-request generation. In plain mode the request follows
// free space >= threshold. In burst mode a request that was high stays
// high until two or fewer bytes are free, or four or fewer with end-of-frame.
// The hold state clears on flush.
module txq_req
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] free,
    input  logic [1:0]    code,
    input  logic          burst,
    input  logic          eof,
    output logic          req
);
    logic [CW-1:0] thr;
    logic          hold_q, keep;

    // Threshold compare and burst hold-over
    always_comb begin
        thr  = CW'(wmark_bytes(code, DEPTH));
        keep = burst && hold_q && (free > CW'(2)) && !(eof && free <= CW'(4));
        req  = (free >= thr) || keep;
    end

    // Remember the last request level for burst hold
    always_ff @(posedge clk) begin
        if (!rst_n || flush) hold_q <= 1'b0;
        else                 hold_q <= req;
    end

    p_burst_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst && free <= CW'(2) && code != 2'b00 && free < thr |-> !req);
    p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst && $past(rst_n) && $past(req) && !$past(flush) && free > CW'(2) && !eof |-> req);
    p_eof_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst && eof && free <= CW'(4) && free < thr |-> !req);
endmodule

// File: rtl/txfifo_req_ctrl.sv
// Module: top of the transmit FIFO data-request controller. Connects the
// staged watermark register, the byte store and the request generator.
// Assumes the host and the MAC run on the same clock.
module txfifo_req_ctrl #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_rst,
    input  logic        retry_rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_wmark,
    input  logic        cfg_update,
    input  logic        burst_en,
    input  logic        host_we,
    input  logic [15:0] host_word,
    input  logic        host_eof,
    input  logic        mac_pop,
    output logic [7:0]  mac_byte,
    output logic        fifo_empty,
    output logic        tx_req,
    output logic        overflow,
    output logic [1:0]  wmark_rd,
    output logic        update_rd
);
    logic [1:0]    act_code;
    logic          flush;
    logic [CW-1:0] free;

    txq_wmark u_wmark (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .retry_rst(retry_rst),
        .cfg_we(cfg_we), .cfg_wmark(cfg_wmark), .cfg_update(cfg_update),
        .pend(wmark_rd), .act(act_code), .upd(update_rd), .flush(flush)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ovf_clr(sw_rst),
        .push(host_we), .word(host_word), .pop(mac_pop),
        .head(mac_byte), .empty(fifo_empty), .free(free), .ovf(overflow)
    );

    txq_req #(.DEPTH(DEPTH)) u_req (
        .clk(clk), .rst_n(rst_n), .flush(flush), .free(free),
        .code(act_code), .burst(burst_en), .eof(host_eof), .req(tx_req)
    );
endmodule

// File: tb/tb_txfifo_req_ctrl.sv
module tb_txfifo_req_ctrl;
    localparam int D = 64;

    logic clk = 1'b0;
    logic rst_n, sw_rst, retry_rst, cfg_we, cfg_update, burst_en;
    logic host_we, host_eof, mac_pop;
    logic [1:0] cfg_wmark;
    logic [15:0] host_word;
    logic [7:0] mac_byte;
    logic fifo_empty, tx_req, overflow, update_rd;
    logic [1:0] wmark_rd;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [7:0] q[$];
    logic [1:0] m_pend, m_act;
    logic m_upd, m_ovf, m_hold;

    always #10 clk = ~clk;

    txfifo_req_ctrl #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .retry_rst(retry_rst),
        .cfg_we(cfg_we), .cfg_wmark(cfg_wmark), .cfg_update(cfg_update),
        .burst_en(burst_en), .host_we(host_we), .host_word(host_word),
        .host_eof(host_eof), .mac_pop(mac_pop), .mac_byte(mac_byte),
        .fifo_empty(fifo_empty), .tx_req(tx_req), .overflow(overflow),
        .wmark_rd(wmark_rd), .update_rd(update_rd)
    );

    function automatic int thr_of(input logic [1:0] c);
        return (c == 2'b00) ? D/4 : (c == 2'b01) ? D/2 : D;
    endfunction

    function automatic bit exp_req(input int fr, input logic [1:0] c, input bit bst,
                                   input bit hld, input bit eof);
        return (fr >= thr_of(c)) || (bst && hld && fr > 2 && !(eof && fr <= 4));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model before the coming edge
    task automatic compare();
        int fr = D - q.size();
        bit er = exp_req(fr, m_act, burst_en, m_hold, host_eof);
        string rt = !burst_en ? "R4" : (host_eof && fr <= 4) ? "R9" : "R8";
        check(tx_req == er, rt, tx_req, er);
        check(fifo_empty == (q.size() == 0), "R2", fifo_empty, q.size() == 0);
        if (q.size() > 0) check(mac_byte == q[0], "R2", mac_byte, q[0]);
        check(overflow == m_ovf, "R3", overflow, m_ovf);
        check(wmark_rd == m_pend, "R5", wmark_rd, m_pend);
        check(update_rd == m_upd, "R6", update_rd, m_upd);
    endtask

    task automatic model_reset();
        q.delete();
        m_pend = 2'b10; m_act = 2'b10; m_upd = 0; m_ovf = 0; m_hold = 0;
    endtask

    // Advance the model by one clock edge
    task automatic model_edge();
        int fr = D - q.size();
        bit er = exp_req(fr, m_act, burst_en, m_hold, host_eof);
        bit load = m_upd || retry_rst;
        if (!rst_n || sw_rst) begin
            model_reset();
            return;
        end
        m_hold = load ? 1'b0 : er;
        if (load) begin
            m_act = m_pend;
            q.delete();
        end else begin
            if (mac_pop && q.size() > 0) void'(q.pop_front());
            if (host_we) begin
                if (fr >= 2) begin
                    q.push_back(host_word[7:0]);
                    q.push_back(host_word[15:8]);
                end else m_ovf = 1;
            end
        end
        if (cfg_we) begin
            m_pend = cfg_wmark;
            m_upd = cfg_update;
        end else if (load) m_upd = 0;
    endtask

    task automatic step();
        #5 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        sw_rst = 0; retry_rst = 0; cfg_we = 0; cfg_update = 0;
        host_we = 0; host_eof = 0; mac_pop = 0;
    endtask

    task automatic push_words(input int n, input bit eof);
        for (int i = 0; i < n; i++) begin
            idle();
            host_we = 1;
            host_word = 16'($urandom);
            host_eof = eof;
            step();
        end
        idle();
    endtask

    task automatic write_cfg(input logic [1:0] c, input bit u);
        idle();
        cfg_we = 1; cfg_wmark = c; cfg_update = u;
        step();
        idle();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        rst_n = 0; burst_en = 0; cfg_wmark = 0; host_word = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        #5;
        // R1: reset state
        check(fifo_empty && !overflow && !update_rd, "R1", {fifo_empty, overflow, update_rd}, 3'b100);
        check(wmark_rd == 2'b10 && tx_req, "R1", {wmark_rd, tx_req}, 3'b101);
        @(negedge clk);

        // R2/R3/R4: fill with plain threshold of D, then overflow
        push_words(D/2 + 2, 0);
        // R2: drain a few bytes in order, one pop while empty later
        idle(); mac_pop = 1; step(); step(); step();
        push_words(2, 0);  // R3: one byte free, then full
        idle();

        // R5: stage a code without update; request logic must not change
        write_cfg(2'b00, 0);
        step();
        check(tx_req == 0, "R5", tx_req, 0);
        // R6: raise update, next edge loads and flushes
        write_cfg(2'b00, 1);
        step();
        check(fifo_empty && !update_rd, "R6", {fifo_empty, update_rd}, 2'b10);

        // R8: burst hold down to two free bytes with threshold D/4
        burst_en = 1;
        push_words(D/2 + 1, 0);
        // R10: software reset with a simultaneous config write
        idle(); sw_rst = 1; cfg_we = 1; cfg_wmark = 2'b01; cfg_update = 1; step(); idle();
        #5;
        check(fifo_empty && !overflow && !update_rd && wmark_rd == 2'b10, "R10",
              {fifo_empty, overflow, update_rd, wmark_rd}, 5'b10010);
        @(negedge clk);

        // R9: burst with threshold D/4, end-of-frame at four free bytes
        write_cfg(2'b00, 1);
        step();
        push_words(D/2 - 3, 0);
        push_words(1, 1);
        idle(); host_eof = 1; step(); idle();

        // R7: stage code then retry reset
        write_cfg(2'b01, 0);
        push_words(3, 0);
        idle(); retry_rst = 1; step(); idle();
        #5;
        check(fifo_empty && !update_rd, "R7", {fifo_empty, update_rd}, 2'b10);
        check(tx_req == 1, "R7", tx_req, 1);
        @(negedge clk);

        // Random phase: blocks with varying fill pressure
        for (int b = 0; b < 25; b++) begin
            int pw = $urandom_range(10, 90);
            int pp = $urandom_range(5, 80);
            burst_en = $urandom_range(0, 1);
            for (int c = 0; c < 160; c++) begin
                idle();
                host_we   = ($urandom_range(0, 99) < pw);
                host_word = 16'($urandom);
                host_eof  = ($urandom_range(0, 7) == 0);
                mac_pop   = ($urandom_range(0, 99) < pp);
                if ($urandom_range(0, 99) == 0) begin
                    cfg_we = 1; cfg_wmark = 2'($urandom); cfg_update = $urandom_range(0, 1);
                end
                retry_rst = ($urandom_range(0, 299) == 0);
                sw_rst    = ($urandom_range(0, 799) == 0);
                step();
            end
        end

        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule